// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block generates and checks the even parity bit that travels with a 32-bit multiplexed address/data bus and its 4-bit command/byte-enable field. It watches the transaction strobes (frame, initiator ready, target ready). It also knows whether the local agent is the initiator or the target of the current transfer, and whether that transfer is a read or a write. From this it decides, clock by clock, whether this agent must drive the parity line or check the parity the other agent drives.

Parity always lags the bits it covers by one clock. The initiator owns the parity line for the clock after an address phase and for the clocks after write-data clocks. The target owns it for the clocks after read-data clocks. In every other valid phase this agent is the receiver. It captures the parity it expects and compares it with the incoming line one clock later, and it flags a mismatch for a single clock.

Top module: `bus_parity_engine`

## Requirements
- R1: While `parOe` is 1, `parOut` equals the XOR of all 36 bits of `adIn` and `cbeIn` sampled on the previous clock, so that the 37 bits together hold an even number of ones.
- R2: An address phase is a clock with `frameN` low while no transaction is open. In the next clock `parOe` is 1 when `isInitiator` is 1 and 0 otherwise.
- R3: In a write transaction (`isWrite`=1), each clock after the address phase with `irdyN` low is a write-data clock. In the next clock the initiator drives parity and the target does not.
- R4: In a read transaction (`isWrite`=0), each clock after the address phase with `trdyN` low is a read-data clock. In the next clock the target drives parity and the initiator does not.
- R5: The data phase completes in a clock with both `irdyN` and `trdyN` low. Parity for that phase is still driven in the following clock. When `frameN` was high in the completing clock, the transaction closes and `parOe` returns to 0 one clock later.
- R6: When a valid phase happened in clock t and this agent was not its driver, `parErr` is 1 during clock t+1 exactly when `parIn` differs from the even parity of the 36 bits of clock t.
- R7: `parErr` stays 0 in a clock that follows an idle clock (no address, write-data or read-data phase) or a clock in which this agent drove parity, whatever `parIn` carries.
- R8: While `rstN` is low, and in the first clock after it rises, `parOe` and `parErr` are 0.
- R9: The target never drives parity for an address phase or a write-data phase, and the initiator never drives parity for a read-data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adIn | input | 32 | Address/data bits as seen on the bus |
| cbeIn | input | 4 | Command/byte-enable bits as seen on the bus (raw levels) |
| frameN | input | 1 | Transaction frame strobe, active low |
| irdyN | input | 1 | Initiator ready strobe, active low |
| trdyN | input | 1 | Target ready strobe, active low |
| isInitiator | input | 1 | 1 when this agent is the initiator of the current transaction |
| isWrite | input | 1 | 1 when the current transaction writes data |
| parIn | input | 1 | Parity line as received from the bus |
| parOut | output | 1 | Parity value to drive |
| parOe | output | 1 | Enable for the parity driver |
| parErr | output | 1 | One-clock pulse on a received parity mismatch |

## Verification
The assertions assume a well-formed transaction: `isInitiator` and `isWrite` are steady from the address phase to the completing clock, `frameN` rises only together with the last initiator-ready clock, and the other agent's parity appears one clock after the bits it covers. The bench builds every transfer through one task that produces only such sequences. It varies the role, the direction, the number of data phases, the target wait states and the data patterns. Corrupted parity is applied on purpose in checked clocks, and also in idle and self-driven clocks to show that those never raise an error.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

  // Strobes handed from the phase control to the parity datapath.
  typedef struct packed {
    logic driveNext;   // this agent owns the parity line next clock
    logic checkNext;   // a valid phase driven by the other agent: check next clock
  } bpe_strobe_t;

endpackage

// File: rtl/bpe_ctrl.sv
module bpe_ctrl
  import bpe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        trdyN,
  input  logic        isInitiator,
  input  logic        isWrite,
  output bpe_strobe_t strobe
);

  logic busyQ;
  logic addrPhase;
  logic wrData;
  logic rdData;
  logic lastDone;
  logic phaseValid;

  // A transaction opens when frame is seen low while the bus is idle.
  assign addrPhase  = !frameN && !busyQ;
  assign wrData     = busyQ && isWrite && !irdyN;
  assign rdData     = busyQ && !isWrite && !trdyN;
  assign lastDone   = busyQ && !irdyN && !trdyN && frameN;
  assign phaseValid = addrPhase || wrData || rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (addrPhase) begin
      busyQ <= 1'b1;
    end else if (lastDone) begin
      busyQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.driveNext = ((addrPhase || wrData) && isInitiator) ||
                       (rdData && !isInitiator);
    strobe.checkNext = phaseValid && !strobe.driveNext;
  end

endmodule

// File: rtl/bpe_datapath.sv
module bpe_datapath
  import bpe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] adIn,
  input  logic [CMD_W-1:0]  cbeIn,
  input  logic              parIn,
  input  bpe_strobe_t       strobe,
  output logic              parOut,
  output logic              parOe,
  output logic              parErr
);

  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0] laneParity;
  logic             sumParity;
  logic             parityQ;
  logic             oeQ;
  logic             chkQ;

  // One XOR tree per byte lane, then a short tree across lanes and command.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneParity[l] = ^adIn[l*8 +: 8];
  end

  assign sumParity = (^laneParity) ^ (^cbeIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parityQ <= 1'b0;
      oeQ     <= 1'b0;
      chkQ    <= 1'b0;
    end else begin
      parityQ <= sumParity;
      oeQ     <= strobe.driveNext;
      chkQ    <= strobe.checkNext;
    end
  end

  // The same registered value serves as drive value and as check reference.
  assign parOut = parityQ;
  assign parOe  = oeQ;
  assign parErr = chkQ && (parIn != parityQ);

endmodule

// File: rtl/bus_parity_engine.sv
module bus_parity_engine
  import bpe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] adIn,
  input  logic [CMD_W-1:0]  cbeIn,
  input  logic              frameN,
  input  logic              irdyN,
  input  logic              trdyN,
  input  logic              isInitiator,
  input  logic              isWrite,
  input  logic              parIn,
  output logic              parOut,
  output logic              parOe,
  output logic              parErr
);

  bpe_strobe_t strobe;

  bpe_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameN      (frameN),
    .irdyN       (irdyN),
    .trdyN       (trdyN),
    .isInitiator (isInitiator),
    .isWrite     (isWrite),
    .strobe      (strobe)
  );

  bpe_datapath #(
    .DATA_W (DATA_W),
    .CMD_W  (CMD_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .adIn   (adIn),
    .cbeIn  (cbeIn),
    .parIn  (parIn),
    .strobe (strobe),
    .parOut (parOut),
    .parOe  (parOe),
    .parErr (parErr)
  );

endmodule

// File: rtl/bpe_checker.sv
module bpe_checker #(
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] adIn,
  input logic [CMD_W-1:0]  cbeIn,
  input logic              frameN,
  input logic              irdyN,
  input logic              trdyN,
  input logic              isInitiator,
  input logic              isWrite,
  input logic              parIn,
  input logic              parOut,
  input logic              parOe,
  input logic              parErr
);

  // R1
  parity_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> (parOut == ^$past({adIn, cbeIn})));

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!parOe && !parErr));

  // R7
  err_not_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> !parOe);

  // R7
  err_needs_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> $past(!frameN || !irdyN || !trdyN));

  // R9
  target_reads_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (parOe && !$past(isInitiator)) |-> !$past(isWrite));

endmodule

bind bus_parity_engine bpe_checker #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .adIn        (adIn),
  .cbeIn       (cbeIn),
  .frameN      (frameN),
  .irdyN       (irdyN),
  .trdyN       (trdyN),
  .isInitiator (isInitiator),
  .isWrite     (isWrite),
  .parIn       (parIn),
  .parOut      (parOut),
  .parOe       (parOe),
  .parErr      (parErr)
);

// File: tb/sim_bus_parity_engine.sv
module sim_bus_parity_engine;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] adIn;
  logic [3:0]  cbeIn;
  logic        frameN, irdyN, trdyN;
  logic        isInitiator, isWrite, parIn;
  logic        parOut, parOe, parErr;

  int total = 0;
  int bad   = 0;

  // expectations for the clock that follows the last driven clock
  bit    expOe   = 1'b0;
  bit    expChk  = 1'b0;
  bit    expPar  = 1'b0;
  bit    pendBad = 1'b0;
  string expTag  = "R8";

  always #10 clk = ~clk;

  bus_parity_engine u0 (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cbeIn(cbeIn),
    .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .isInitiator(isInitiator), .isWrite(isWrite), .parIn(parIn),
    .parOut(parOut), .parOe(parOe), .parErr(parErr)
  );

  function automatic bit evenPar(input logic [31:0] a, input logic [3:0] c);
    int ones = 0;
    for (int b = 0; b < 32; b++) ones += int'(a[b]);
    for (int b = 0; b < 4; b++)  ones += int'(c[b]);
    return ones % 2 == 1;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  // kind: 0 idle/no phase, 1 address, 2 write data, 3 read data.
  // Called at a falling edge: checks the outputs caused by the previous
  // clock, then drives the inputs for the next rising edge.
  task automatic cyc(input logic f, input logic i, input logic t,
                     input logic [31:0] a, input logic [3:0] c,
                     input int kind, input bit corrupt, input string tag);
    bit drv;
    check(parOe === expOe, expTag, "parOe", int'(parOe), int'(expOe));
    if (expOe) check(parOut === expPar, "R1", "parOut", int'(parOut), int'(expPar));
    parIn = expPar ^ pendBad;
    #1;
    check(parErr === (expChk && pendBad), expChk ? "R6" : "R7", "parErr",
          int'(parErr), int'(expChk && pendBad));
    frameN = f; irdyN = i; trdyN = t; adIn = a; cbeIn = c;
    drv = (kind == 1 || kind == 2) ? isInitiator : (kind == 3) ? !isInitiator : 1'b0;
    expOe   = drv;
    expChk  = (kind != 0) && !drv;
    expPar  = evenPar(a, c);
    pendBad = corrupt;
    expTag  = (kind != 0 && !drv && kind != 0) ? "R9" : tag;
    @(negedge clk);
  endtask

  task automatic txn(input bit ini, input bit wr, input int n, input int tWait,
                     input int seed, input bit [7:0] badMask);
    logic [31:0] addr;
    addr = 32'h9E37_79B9 * (seed + 1);
    isInitiator = ini;
    isWrite     = wr;
    cyc(1'b0, 1'b1, 1'b1, addr, wr ? 4'b0111 : 4'b0110, 1, badMask[0], "R2");
    for (int k = 0; k < n; k++) begin
      logic [31:0] d;
      logic [3:0]  be;
      logic        last;
      d    = addr ^ (32'h0101_0101 * (k + 3)) ^ {seed[7:0], 24'h5A3C1E};
      be   = 4'(k + seed);
      last = (k == n - 1);
      for (int w = 0; w < tWait; w++)
        cyc(last, 1'b0, 1'b1, d, be, wr ? 2 : 0, 1'b0, wr ? "R3" : "R4");
      cyc(last, 1'b0, 1'b0, d, be, wr ? 2 : 3, badMask[k+1], "R5");
    end
    cyc(1'b1, 1'b1, 1'b1, 32'h0, 4'h0, 0, 1'b1, "R5");
  endtask

  initial begin
    rstN = 1'b0; adIn = '0; cbeIn = '0;
    frameN = 1'b1; irdyN = 1'b1; trdyN = 1'b1;
    isInitiator = 1'b1; isWrite = 1'b1; parIn = 1'b0;
    repeat (3) @(negedge clk);
    // R8: quiet during reset even with frame low on the bus
    frameN = 1'b0;
    @(negedge clk);
    check(parOe === 1'b0, "R8", "parOe in reset", int'(parOe), 0);
    check(parErr === 1'b0, "R8", "parErr in reset", int'(parErr), 0);
    frameN = 1'b1;
    rstN = 1'b1;
    @(negedge clk);
    check(parOe === 1'b0, "R8", "parOe after reset", int'(parOe), 0);

    // R7: idle clocks with wrong parity never flag
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 1'b1, 32'hFFFF_0000 >> k, 4'hA, 0, 1'b1, "R7");

    // initiator write: R2, R3, R5; corrupt parIn while driving (R7)
    txn(1'b1, 1'b1, 3, 1, 1, 8'hFF);
    // initiator read: address driven, read data checked (R4, R6, R9)
    txn(1'b1, 1'b0, 2, 2, 2, 8'b0000_0110);
    // target write: everything checked (R6, R9)
    txn(1'b0, 1'b1, 3, 0, 3, 8'b0000_1011);
    // target read: address checked, data driven (R4, R5)
    txn(1'b0, 1'b0, 3, 1, 4, 8'b0000_0001);

    // sweep: every role/direction, varying length, waits and corruption
    for (int s = 0; s < 64; s++) begin
      txn(s[0], s[1], 1 + (s % 4), (s / 4) % 3, s + 10, 8'(s * 37));
      if (s % 5 == 0) cyc(1'b1, 1'b1, 1'b1, 32'(s), 4'(s), 0, 1'b1, "R7");
    end
    cyc(1'b1, 1'b1, 1'b1, 32'h0, 4'h0, 0, 1'b0, "R5");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule